// File: doc/BRIEF.md
# Shared Shift-Add Reciprocal-Root-Two Scaler

This block scales the two complex results of one radix-2 butterfly stage, its sum branch and its difference branch, by 1/√2. It uses one constant scaler built only from shifts and adds, not two general complex multipliers. When the butterfly presents a pair of results with `in_valid`, the block captures both. A small scheduler feeds the sum branch into the shared scaler on the next cycle. The difference branch waits in a one-deep holding register and is fed in on the cycle after that. The real and imaginary parts go through two identical, independent scaler lanes.

Each real value x is scaled as x + (1 + 2^-2)·(2^-6 − 2^-2)·x. The coefficient is 181/256 ≈ 0.70703. The arithmetic uses two guard bits above the data width, and the result is truncated back to the data width. The scaled value goes into an output register, together with a tag that says which branch it came from. The sum result is always emitted first and the difference result second.

Top module: `fft_shared_rsqrt2`

## Requirements
- R1: While reset is high and after it is released, `out_valid` is 0, `out_tag` is 0 and both output parts are 0 until the first transaction.
- R2: When `in_valid` is high in cycle k, the scaled sum branch appears in cycle k+2 with `out_valid`=1 and `out_tag`=0 (0 marks the sum branch).
- R3: The scaled difference branch appears in cycle k+3, immediately after the sum result, with `out_valid`=1 and `out_tag`=1 (1 marks the difference branch).
- R4: Each output part y for input part x is within ±2 LSB of floor(x·181/256). This holds for every signed value x at the configured width, and the real and imaginary parts are scaled independently.
- R5: Scaling never overflows. The output has |y| ≤ |x|, and y is zero or has the same sign as x.
- R6: `out_valid` is high only in the two cycles that carry results of an accepted transaction.
- R7: When `out_valid` is low, `out_re` and `out_im` keep their last value.
- R8: Branch inputs are sampled only in the cycle where `in_valid` is high. Changes to them in other cycles do not affect the results. Transactions are accepted at most once every two cycles, and back-to-back transactions at that spacing produce a gapless result stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Butterfly results present this cycle |
| sum_re | input | DW | Sum branch, real part (signed) |
| sum_im | input | DW | Sum branch, imaginary part (signed) |
| diff_re | input | DW | Difference branch, real part (signed) |
| diff_im | input | DW | Difference branch, imaginary part (signed) |
| out_valid | output | 1 | Scaled result present |
| out_tag | output | 1 | Source of result: 0 sum, 1 difference |
| out_re | output | DW | Scaled real part (signed) |
| out_im | output | DW | Scaled imaginary part (signed) |

## Verification
The assertions assume that `in_valid` is never high on two consecutive cycles. The sharing scheme needs this, because each transaction occupies the scaler for two cycles. A dedicated property checks that rule on the input. The sign check relates an output to the sum input sampled two cycles earlier, so it assumes that the capture happened in that cycle. The stimulus always leaves at least one idle cycle between transactions, both in the isolated sweep and in the dense stream. During the idle cycles it changes the branch inputs deliberately, to show that only the captured values are used.

// File: rtl/fft_scale_pkg.sv
package fft_scale_pkg;

    typedef enum logic {
        SRC_SUM  = 1'b0,
        SRC_DIFF = 1'b1
    } src_tag_e;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_EMIT_SUM  = 2'd1,
        ST_EMIT_DIFF = 2'd2
    } sched_st_e;

    // Guard bits carried above the data width inside the scaler.
    localparam int GUARD_BITS = 2;
    // Shift amounts of the decomposition 1 + (1 + 2^-2)(2^-6 - 2^-2).
    localparam int SH_FINE    = 6;
    localparam int SH_COARSE  = 2;
    localparam int SH_TRIM    = 2;

endpackage

// File: rtl/rsqrt2_shift_add.sv
module rsqrt2_shift_add
    import fft_scale_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic signed [DW-1:0] x,
    output logic signed [DW-1:0] y
);
    localparam int EW = DW + GUARD_BITS;

    logic signed [EW-1:0] xe;
    logic signed [EW-1:0] t_fine;
    logic signed [EW-1:0] t_coarse;
    logic signed [EW-1:0] diff_a;
    logic signed [EW-1:0] trim_a;
    logic signed [EW-1:0] corr;
    logic signed [EW-1:0] total;

    always_comb begin
        xe       = signed'({{GUARD_BITS{x[DW-1]}}, x});
        t_fine   = xe >>> SH_FINE;
        t_coarse = xe >>> SH_COARSE;
        diff_a   = t_fine - t_coarse;
        trim_a   = diff_a >>> SH_TRIM;
        corr     = diff_a + trim_a;
        total    = xe + corr;
        y        = total[DW-1:0];
    end

endmodule

// File: rtl/rsqrt2_sched.sv
module rsqrt2_sched
    import fft_scale_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] sum_re,
    input  logic signed [DW-1:0] sum_im,
    input  logic signed [DW-1:0] diff_re,
    input  logic signed [DW-1:0] diff_im,
    output logic                 sel_valid,
    output src_tag_e             sel_tag,
    output logic signed [DW-1:0] sel_re,
    output logic signed [DW-1:0] sel_im
);
    sched_st_e            st_q;
    logic signed [DW-1:0] sum_re_q;
    logic signed [DW-1:0] sum_im_q;
    logic signed [DW-1:0] hold_re_q;
    logic signed [DW-1:0] hold_im_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            sum_re_q  <= '0;
            sum_im_q  <= '0;
            hold_re_q <= '0;
            hold_im_q <= '0;
        end else begin
            if (in_valid) begin
                sum_re_q  <= sum_re;
                sum_im_q  <= sum_im;
                hold_re_q <= diff_re;
                hold_im_q <= diff_im;
                st_q      <= ST_EMIT_SUM;
            end else if (st_q == ST_EMIT_SUM) begin
                st_q      <= ST_EMIT_DIFF;
            end else begin
                st_q      <= ST_IDLE;
            end
        end
    end

    always_comb begin
        sel_valid = (st_q != ST_IDLE);
        if (st_q == ST_EMIT_DIFF) begin
            sel_tag = SRC_DIFF;
            sel_re  = hold_re_q;
            sel_im  = hold_im_q;
        end else begin
            sel_tag = SRC_SUM;
            sel_re  = sum_re_q;
            sel_im  = sum_im_q;
        end
    end

endmodule

// File: rtl/fft_shared_rsqrt2.sv
module fft_shared_rsqrt2
    import fft_scale_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] sum_re,
    input  logic signed [DW-1:0] sum_im,
    input  logic signed [DW-1:0] diff_re,
    input  logic signed [DW-1:0] diff_im,
    output logic                 out_valid,
    output logic                 out_tag,
    output logic signed [DW-1:0] out_re,
    output logic signed [DW-1:0] out_im
);
    localparam int NLANE = 2;

    logic                 sel_valid;
    src_tag_e             sel_tag;
    logic signed [DW-1:0] sel_re;
    logic signed [DW-1:0] sel_im;
    logic signed [DW-1:0] lane_in  [NLANE];
    logic signed [DW-1:0] lane_out [NLANE];

    rsqrt2_sched #(.DW(DW)) u_sched (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .sum_re    (sum_re),
        .sum_im    (sum_im),
        .diff_re   (diff_re),
        .diff_im   (diff_im),
        .sel_valid (sel_valid),
        .sel_tag   (sel_tag),
        .sel_re    (sel_re),
        .sel_im    (sel_im)
    );

    assign lane_in[0] = sel_re;
    assign lane_in[1] = sel_im;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        rsqrt2_shift_add #(.DW(DW)) u_scale (
            .x (lane_in[g]),
            .y (lane_out[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_tag   <= 1'b0;
            out_re    <= '0;
            out_im    <= '0;
        end else begin
            out_valid <= sel_valid;
            if (sel_valid) begin
                out_tag <= sel_tag;
                out_re  <= lane_out[0];
                out_im  <= lane_out[1];
            end
        end
    end

endmodule

// File: rtl/rsqrt2_chk.sv
module rsqrt2_chk #(
    parameter int DW = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic signed [DW-1:0] sum_re,
    input logic signed [DW-1:0] sum_im,
    input logic                 out_valid,
    input logic                 out_tag,
    input logic signed [DW-1:0] out_re,
    input logic signed [DW-1:0] out_im
);
    // R8: input rule, at most one transaction every two cycles
    a_r8_input_spacing: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> !in_valid);

    // R2
    a_r2_sum_latency: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##1 (out_valid && !out_tag));

    // R3
    a_r3_diff_follows: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_tag) |=> (out_valid && out_tag));

    // R6
    a_r6_diff_source: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_tag) |-> $past(in_valid, 3));

    a_r6_sum_source: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_tag) |-> $past(in_valid, 2));

    // R7
    a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(out_re) && $stable(out_im)));

    // R5
    a_r5_sign_re: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_tag) |->
            (out_re == '0 || out_re[DW-1] == $past(sum_re[DW-1], 2)));

    a_r5_sign_im: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_tag) |->
            (out_im == '0 || out_im[DW-1] == $past(sum_im[DW-1], 2)));

endmodule

bind fft_shared_rsqrt2 rsqrt2_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .sum_re    (sum_re),
    .sum_im    (sum_im),
    .out_valid (out_valid),
    .out_tag   (out_tag),
    .out_re    (out_re),
    .out_im    (out_im)
);

// File: tb/sim_fft_shared_rsqrt2.sv
module sim_fft_shared_rsqrt2;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 8;
    localparam int NSTREAM    = 8;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] sum_re = '0, sum_im = '0, diff_re = '0, diff_im = '0;
    logic                 out_valid, out_tag;
    logic signed [DW-1:0] out_re, out_im;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fft_shared_rsqrt2 #(.DW(DW)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .sum_re(sum_re), .sum_im(sum_im), .diff_re(diff_re), .diff_im(diff_im),
        .out_valid(out_valid), .out_tag(out_tag), .out_re(out_re), .out_im(out_im)
    );

    function automatic int ref_scale(int x);
        int p;
        p = x * 181;
        return p >>> 8;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R4 and R5 on one scaled part
    task automatic chk_part(string req, int x, int y);
        int r;
        int ax;
        int ay;
        r  = ref_scale(x);
        ax = (x < 0) ? -x : x;
        ay = (y < 0) ? -y : y;
        chk((y - r <= 2) && (r - y <= 2), {req, " R4 tolerance"}, y, r);
        chk(ay <= ax, "R5 magnitude", ay, ax);
        chk(y == 0 || ((y < 0) == (x < 0)), "R5 sign", y, x);
    endtask

    task automatic chk_result(string req, bit tag, int xr, int xi);
        chk(out_valid == 1'b1, {req, " valid"}, int'(out_valid), 1);
        chk(out_tag == tag, {req, " tag"}, int'(out_tag), int'(tag));
        chk_part(req, xr, int'(out_re));
        chk_part(req, xi, int'(out_im));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic signed [DW-1:0] s_re [NSTREAM];
        logic signed [DW-1:0] s_im [NSTREAM];
        logic signed [DW-1:0] d_re [NSTREAM];
        logic signed [DW-1:0] d_im [NSTREAM];

        repeat (3) @(negedge clk);
        // R1 during reset
        chk(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
        chk(out_tag == 1'b0, "R1 tag", int'(out_tag), 0);
        chk(out_re == 0 && out_im == 0, "R1 data", int'(out_re), 0);

        // Exhaustive sweep: each port sees every signed value once
        for (int v = -(1 << (DW-1)); v < (1 << (DW-1)); v++) begin
            logic signed [DW-1:0] a, b, c, d;
            a = DW'(v);
            b = ~a;
            c = a ^ DW'(8'h55);
            d = DW'(v * 37 + 11);
            @(negedge clk);
            sum_re = a; sum_im = b; diff_re = c; diff_im = d;
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            // R8: scramble inputs outside the valid cycle
            sum_re = ~a; sum_im = c; diff_re = b; diff_im = ~d;
            chk(out_valid == 1'b0, "R2 not early", int'(out_valid), 0);
            @(negedge clk);
            chk_result("R2 sum", 1'b0, int'(a), int'(b));
            @(negedge clk);
            chk_result("R3 diff", 1'b1, int'(c), int'(d));
            begin
                logic signed [DW-1:0] kr, ki;
                kr = out_re;
                ki = out_im;
                @(negedge clk);
                chk(out_valid == 1'b0, "R6 idle", int'(out_valid), 0);
                chk(out_re == kr, "R7 hold re", int'(out_re), int'(kr));
                chk(out_im == ki, "R7 hold im", int'(out_im), int'(ki));
            end
        end

        // R8: dense stream, one transaction every two cycles
        for (int k = 0; k < NSTREAM; k++) begin
            s_re[k] = DW'(k * 29 - 100);
            s_im[k] = DW'(127 - k * 31);
            d_re[k] = DW'(-128 + k * 17);
            d_im[k] = DW'(k * 45 + 3);
        end
        for (int k = 0; k < NSTREAM; k++) begin
            @(negedge clk);
            if (k > 0)
                chk_result("R8 stream sum", 1'b0, int'(s_re[k-1]), int'(s_im[k-1]));
            sum_re = s_re[k]; sum_im = s_im[k]; diff_re = d_re[k]; diff_im = d_im[k];
            in_valid = 1'b1;
            @(negedge clk);
            if (k > 0)
                chk_result("R8 stream diff", 1'b1, int'(d_re[k-1]), int'(d_im[k-1]));
            in_valid = 1'b0;
            sum_re = '0; sum_im = '1; diff_re = '1; diff_im = '0;
        end
        @(negedge clk);
        chk_result("R8 stream sum", 1'b0, int'(s_re[NSTREAM-1]), int'(s_im[NSTREAM-1]));
        @(negedge clk);
        chk_result("R8 stream diff", 1'b1, int'(d_re[NSTREAM-1]), int'(d_im[NSTREAM-1]));
        @(negedge clk);
        chk(out_valid == 1'b0, "R6 stream end", int'(out_valid), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule